// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This unit collects event pulses from the command, response and data engines of an SD host and keeps them as pending requests in a 32-bit status register. A 32-bit mask register decides which pending requests reach the single interrupt line. Four of the status bits are summaries of error classes. Each summary is backed by a detail register that tells apart errors on ordinary commands from errors on the automatically issued stop command (CMD12), and errors in read data from errors in write CRC status.

Software reads the status word and acknowledges a bit by writing a zero to it. A one in the written word leaves that bit alone. When a summary bit is acknowledged, the detail causes behind it are cleared too. A soft reset strobe clears every pending request and all detail causes, and keeps the mask.

Top module: `sd_irq_unit`

## Requirements
- R1: After reset the status and detail words are zero, the mask word holds a one at every implemented status bit (bits 0, 2, 3, 4, 17 to 22, 24 and 25; all others read 0), and the interrupt output is low.
- R2: A pulse on `evtPulse` at a direct event bit (0 response end, 2 data end, 3 card removed, 4 card inserted, 20 write to full FIFO, 21 read from empty FIFO, 24 receive data ready, 25 transmit data requested) sets that status bit at the next clock edge. Pulses at any other position of `evtPulse` have no effect.
- R3: A write with `stWrEn` clears every implemented status bit whose written value is 0 and leaves every bit whose written value is 1 unchanged.
- R4: When an event for a bit arrives in the same cycle as a write-zero acknowledge of that bit, the bit stays set.
- R5: A pulse on `detailPulse` latches that detail bit and sets its summary status bit: bit 19 (data timeout) from detail bits 22, 21, 20; bit 22 (response timeout) from detail bits 17 (stop command) and 16 (ordinary); bit 17 (CRC error) from detail bits 11 (write CRC status), 10 (read data), 9 (stop command response), 8 (ordinary response); bit 18 (end-bit error) from detail bits 5, 4, 3, 2 in the same four categories. Other detail positions have no effect.
- R6: Acknowledging a summary status bit clears all detail bits of its group and no detail bit of any other group; a detail pulse in the same cycle as that acknowledge stays latched together with its summary bit.
- R7: The registered interrupt output equals the OR over all bits of status AND NOT mask, in the same cycle as the status and mask it reflects; a mask bit of 1 blocks its source and 0 passes it.
- R8: A `softRst` pulse clears all status and detail bits at the next edge, overriding events in the same cycle, and leaves the mask unchanged.
- R9: A write with `maskWrEn` loads the mask at the implemented status positions only; all other mask bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous clear of status and detail |
| evtPulse | input | 32 | Single-cycle event pulses, one per status bit position |
| detailPulse | input | 32 | Single-cycle error cause pulses, one per detail bit position |
| stWrEn | input | 1 | Status write strobe (write-zero acknowledge) |
| stWrData | input | 32 | Status write data |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrData | input | 32 | Mask write data |
| statusOut | output | 32 | Pending request word |
| detailOut | output | 32 | Latched error causes |
| maskOut | output | 32 | Current mask word |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with its default 32-bit status and detail widths, which puts every implemented bit position and every unimplemented neighbour of them within reach of the stimulus. With those widths it can drive events onto holes in the map, race a detail cause against the acknowledge of its own summary, and acknowledge one error group while another stays pending, so the group boundaries of the detail fold are checked from both sides.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;

  localparam int STAT_W  = 32;
  localparam int DET_W   = 32;
  localparam int NUM_GRP = 4;

  // Direct event positions in the status word
  localparam int BIT_RESP_END  = 0;
  localparam int BIT_DATA_END  = 2;
  localparam int BIT_CARD_OUT  = 3;
  localparam int BIT_CARD_IN   = 4;
  localparam int BIT_FIFO_OVF  = 20;
  localparam int BIT_FIFO_UNF  = 21;
  localparam int BIT_RX_READY  = 24;
  localparam int BIT_TX_REQ    = 25;

  // Summary error positions in the status word
  localparam int BIT_CRC_ERR   = 17;
  localparam int BIT_END_ERR   = 18;
  localparam int BIT_DATA_TO   = 19;
  localparam int BIT_RESP_TO   = 22;

  localparam logic [STAT_W-1:0] DIRECT_MASK =
      (STAT_W'(1) << BIT_RESP_END) | (STAT_W'(1) << BIT_DATA_END) |
      (STAT_W'(1) << BIT_CARD_OUT) | (STAT_W'(1) << BIT_CARD_IN)  |
      (STAT_W'(1) << BIT_FIFO_OVF) | (STAT_W'(1) << BIT_FIFO_UNF) |
      (STAT_W'(1) << BIT_RX_READY) | (STAT_W'(1) << BIT_TX_REQ);

  localparam logic [STAT_W-1:0] SUM_MASK =
      (STAT_W'(1) << BIT_CRC_ERR) | (STAT_W'(1) << BIT_END_ERR) |
      (STAT_W'(1) << BIT_DATA_TO) | (STAT_W'(1) << BIT_RESP_TO);

  localparam logic [STAT_W-1:0] STAT_IMPL = DIRECT_MASK | SUM_MASK;

  // Status position of each summary group
  function automatic int grpBit(input int g);
    case (g)
      0:       grpBit = BIT_DATA_TO;
      1:       grpBit = BIT_RESP_TO;
      2:       grpBit = BIT_CRC_ERR;
      default: grpBit = BIT_END_ERR;
    endcase
  endfunction

  // Detail causes folded into each summary group
  function automatic logic [DET_W-1:0] grpDet(input int g);
    case (g)
      0:       grpDet = (DET_W'(1) << 22) | (DET_W'(1) << 21) | (DET_W'(1) << 20);
      1:       grpDet = (DET_W'(1) << 17) | (DET_W'(1) << 16);
      2:       grpDet = (DET_W'(1) << 11) | (DET_W'(1) << 10) |
                        (DET_W'(1) << 9)  | (DET_W'(1) << 8);
      default: grpDet = (DET_W'(1) << 5) | (DET_W'(1) << 4) |
                        (DET_W'(1) << 3) | (DET_W'(1) << 2);
    endcase
  endfunction

  function automatic logic [DET_W-1:0] detImpl();
    logic [DET_W-1:0] acc;
    acc = '0;
    for (int g = 0; g < NUM_GRP; g++) acc = acc | grpDet(g);
    return acc;
  endfunction

  localparam logic [DET_W-1:0] DET_IMPL = detImpl();

  // Strobes from control to datapath
  typedef struct packed {
    logic [STAT_W-1:0] ackClr;   // status bits to acknowledge
    logic              maskLd;   // load mask
    logic [STAT_W-1:0] maskVal;  // value to load
    logic              softClr;  // clear status and detail
  } irqStrobe_t;

endpackage

// File: rtl/sd_irq_ctrl.sv
module sd_irq_ctrl
  import sd_irq_pkg::*;
(
  input  logic              softRst,
  input  logic              stWrEn,
  input  logic [STAT_W-1:0] stWrData,
  input  logic              maskWrEn,
  input  logic [STAT_W-1:0] maskWrData,
  output irqStrobe_t        strb
);

  always_comb begin
    strb.softClr = softRst;
    // write-zero acknowledge: a 0 in the data clears an implemented bit
    strb.ackClr  = stWrEn ? (~stWrData & STAT_IMPL) : '0;
    strb.maskLd  = maskWrEn;
    strb.maskVal = maskWrData & STAT_IMPL;
  end

endmodule

// File: rtl/sd_irq_dp.sv
module sd_irq_dp
  import sd_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        strb,
  input  logic [STAT_W-1:0] evtPulse,
  input  logic [DET_W-1:0]  detailPulse,
  output logic [STAT_W-1:0] statusQ,
  output logic [DET_W-1:0]  detailQ,
  output logic [STAT_W-1:0] maskQ,
  output logic              irqQ
);

  logic [NUM_GRP-1:0] grpHit;
  logic [NUM_GRP-1:0] grpAck;
  logic [STAT_W-1:0]  sumSet;
  logic [DET_W-1:0]   detClr;
  logic [STAT_W-1:0]  statusNext;
  logic [DET_W-1:0]   detailNext;
  logic [STAT_W-1:0]  maskNext;
  logic               irqNext;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    assign grpHit[g] = |(detailPulse & grpDet(g));
    assign grpAck[g] = strb.ackClr[grpBit(g)];
  end

  always_comb begin
    sumSet = '0;
    detClr = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grpHit[g]) sumSet[grpBit(g)] = 1'b1;
      if (grpAck[g]) detClr = detClr | grpDet(g);
    end
  end

  always_comb begin
    if (strb.softClr) begin
      statusNext = '0;
      detailNext = '0;
    end else begin
      // new events win over a same-cycle acknowledge
      statusNext = (statusQ & ~strb.ackClr) | (evtPulse & DIRECT_MASK) | sumSet;
      detailNext = (detailQ & ~detClr) | (detailPulse & DET_IMPL);
    end
    maskNext = strb.maskLd ? strb.maskVal : maskQ;
    irqNext  = |(statusNext & ~maskNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      detailQ <= '0;
      maskQ   <= STAT_IMPL;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusNext;
      detailQ <= detailNext;
      maskQ   <= maskNext;
      irqQ    <= irqNext;
    end
  end

endmodule

// File: rtl/sd_irq_unit.sv
module sd_irq_unit
  import sd_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic [STAT_W-1:0] evtPulse,
  input  logic [DET_W-1:0]  detailPulse,
  input  logic              stWrEn,
  input  logic [STAT_W-1:0] stWrData,
  input  logic              maskWrEn,
  input  logic [STAT_W-1:0] maskWrData,
  output logic [STAT_W-1:0] statusOut,
  output logic [DET_W-1:0]  detailOut,
  output logic [STAT_W-1:0] maskOut,
  output logic              irqOut
);

  irqStrobe_t strb;

  sd_irq_ctrl ctrl_i (
    .softRst   (softRst),
    .stWrEn    (stWrEn),
    .stWrData  (stWrData),
    .maskWrEn  (maskWrEn),
    .maskWrData(maskWrData),
    .strb      (strb)
  );

  sd_irq_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .evtPulse   (evtPulse),
    .detailPulse(detailPulse),
    .statusQ    (statusOut),
    .detailQ    (detailOut),
    .maskQ      (maskOut),
    .irqQ       (irqOut)
  );

endmodule

// File: rtl/sd_irq_chk.sv
module sd_irq_chk
  import sd_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              softRst,
  input logic [STAT_W-1:0] evtPulse,
  input logic              stWrEn,
  input logic [STAT_W-1:0] stWrData,
  input logic [STAT_W-1:0] statusOut,
  input logic [DET_W-1:0]  detailOut,
  input logic [STAT_W-1:0] maskOut,
  input logic              irqOut
);

  // R2 and R4: a direct event is always visible one edge later
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    !softRst |=> ((statusOut & $past(evtPulse & DIRECT_MASK)) == $past(evtPulse & DIRECT_MASK)));

  // R3: ones in the written word keep pending bits
  a_r3_write_one_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (stWrEn && !softRst) |=> ((statusOut & $past(statusOut & stWrData)) == $past(statusOut & stWrData)));

  // R7: interrupt line matches pending unmasked requests
  a_r7_irq_match: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(statusOut & ~maskOut));

  // R8: soft reset empties status and detail
  a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (statusOut == '0 && detailOut == '0));

  // R5: a latched cause always has its summary bit pending
  a_r5_sum_covers: assert property (@(posedge clk) disable iff (!rstN)
    (((detailOut & grpDet(0)) == '0) || statusOut[grpBit(0)]) &&
    (((detailOut & grpDet(1)) == '0) || statusOut[grpBit(1)]) &&
    (((detailOut & grpDet(2)) == '0) || statusOut[grpBit(2)]) &&
    (((detailOut & grpDet(3)) == '0) || statusOut[grpBit(3)]));

  // R9: mask holds nothing outside the implemented map
  a_r9_mask_impl: assert property (@(posedge clk) disable iff (!rstN)
    (maskOut & ~STAT_IMPL) == '0);

endmodule

bind sd_irq_unit sd_irq_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .softRst  (softRst),
  .evtPulse (evtPulse),
  .stWrEn   (stWrEn),
  .stWrData (stWrData),
  .statusOut(statusOut),
  .detailOut(detailOut),
  .maskOut  (maskOut),
  .irqOut   (irqOut)
);

// File: tb/sd_irq_unit_tb_top.sv
module sd_irq_unit_tb_top;

  localparam logic [31:0] IMPL   = 32'h037E_001D;
  localparam logic [31:0] DIRECT = 32'h0330_001D;
  localparam logic [31:0] G_DTO  = 32'h0070_0000;  // -> status 19
  localparam logic [31:0] G_RTO  = 32'h0003_0000;  // -> status 22
  localparam logic [31:0] G_CRC  = 32'h0000_0F00;  // -> status 17
  localparam logic [31:0] G_END  = 32'h0000_003C;  // -> status 18

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic [31:0] evtPulse = '0;
  logic [31:0] detailPulse = '0;
  logic        stWrEn = 1'b0;
  logic [31:0] stWrData = '0;
  logic        maskWrEn = 1'b0;
  logic [31:0] maskWrData = '0;
  logic [31:0] statusOut, detailOut, maskOut;
  logic        irqOut;

  always #2 clk = ~clk;  // 250 MHz

  sd_irq_unit dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .evtPulse(evtPulse),
    .detailPulse(detailPulse), .stWrEn(stWrEn), .stWrData(stWrData),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .statusOut(statusOut),
    .detailOut(detailOut), .maskOut(maskOut), .irqOut(irqOut)
  );

  typedef struct {
    logic [31:0] st;
    logic [31:0] det;
    logic [31:0] msk;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mSt = '0, mDet = '0, mMsk = IMPL;

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expectation per edge, samples after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "status", statusOut, e.st);
      cmp(e.tag, "detail", detailOut, e.det);
      cmp(e.tag, "mask", maskOut, e.msk);
      cmp(e.tag, "irq", {31'd0, irqOut}, {31'd0, e.irq});
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic [31:0] ev, input logic [31:0] dt,
                      input logic wE, input logic [31:0] wD,
                      input logic mE, input logic [31:0] mD,
                      input logic sr, input string tag);
    exp_t e;
    logic [31:0] ack, clr, sumSet;
    @(negedge clk);
    evtPulse = ev; detailPulse = dt; stWrEn = wE; stWrData = wD;
    maskWrEn = mE; maskWrData = mD; softRst = sr;
    if (sr) begin
      mSt = '0; mDet = '0;
    end else begin
      ack = wE ? (~wD & IMPL) : 32'd0;
      clr = '0;
      if (ack[19]) clr |= G_DTO;
      if (ack[22]) clr |= G_RTO;
      if (ack[17]) clr |= G_CRC;
      if (ack[18]) clr |= G_END;
      sumSet = '0;
      if ((dt & G_DTO) != 0) sumSet[19] = 1'b1;
      if ((dt & G_RTO) != 0) sumSet[22] = 1'b1;
      if ((dt & G_CRC) != 0) sumSet[17] = 1'b1;
      if ((dt & G_END) != 0) sumSet[18] = 1'b1;
      mSt  = (mSt & ~ack) | (ev & DIRECT) | sumSet;
      mDet = (mDet & ~clr) | (dt & (G_DTO | G_RTO | G_CRC | G_END));
    end
    if (mE) mMsk = mD & IMPL;
    e.st = mSt; e.det = mDet; e.msk = mMsk; e.irq = |(mSt & ~mMsk); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step('0, '0, 1'b0, '0, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset values
    idle("R1");
    // R2: direct events at 0 and 24, masked so no irq
    step(32'h0100_0001, '0, 0, '0, 0, '0, 0, "R2");
    // R2: events at unimplemented positions ignored
    step(32'hC0FF_00E2 & ~DIRECT, '0, 0, '0, 0, '0, 0, "R2");
    // R7: unmask bit 0 -> irq
    step('0, '0, 0, '0, 1, 32'hFFFF_FFFE, 0, "R7");
    // R9: mask write with unimplemented bits
    step('0, '0, 0, '0, 1, 32'hFFFF_FFFE, 0, "R9");
    // R3: writing all ones keeps status
    step('0, '0, 1, 32'hFFFF_FFFF, 0, '0, 0, "R3");
    // R3: write zero at bit 0 only
    step('0, '0, 1, 32'hFFFF_FFFE, 0, '0, 0, "R3");
    // R4: event on 24 with ack of 24 in same cycle
    step(32'h0100_0000, '0, 1, 32'hFEFF_FFFF, 0, '0, 0, "R4");
    // R7: mask 24 back, then clear it
    step('0, '0, 1, 32'hFEFF_FFFF, 1, 32'hFFFF_FFFF, 0, "R7");
    // R5: detail causes in each group
    step('0, 32'h0040_0000, 0, '0, 1, 32'h0000_0000, 0, "R5");
    step('0, 32'h0001_0200, 0, '0, 0, '0, 0, "R5");
    step('0, 32'h0000_0008, 0, '0, 0, '0, 0, "R5");
    // R5: undefined detail positions ignored
    step('0, 32'h808C_F0C3, 0, '0, 0, '0, 0, "R5");
    // R6: ack data timeout summary, other groups stay
    step('0, '0, 1, 32'hFFF7_FFFF, 0, '0, 0, "R6");
    // R6: ack CRC summary while a new CRC cause arrives
    step('0, 32'h0000_0100, 1, 32'hFFFD_FFFF, 0, '0, 0, "R6");
    // R6: ack response timeout and end-bit summaries together
    step('0, '0, 1, 32'hFFBB_FFFF, 0, '0, 0, "R6");
    // R2: FIFO error events 20, 21 and card bits
    step(32'h0030_0018, '0, 0, '0, 0, '0, 0, "R2");
    // R8: soft reset overrides same-cycle events, mask kept
    step(32'h0200_0004, 32'h0000_0020, 0, '0, 0, '0, 1, "R8");
    idle("R8");
    // R7: fully masked event gives no irq
    step(32'h0000_0004, '0, 0, '0, 1, 32'h0000_0004, 0, "R7");
    idle("R7");
    @(negedge clk);
    evtPulse = '0; detailPulse = '0; stWrEn = 0; maskWrEn = 0; softRst = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    finishRun();
  end

endmodule